// File: doc/BRIEF.md
# Weighted Two-Queue Descriptor Scheduler

This block collects 161-bit descriptor entries from a parameterised set of channels (2, 4 or 8). Each entry has a priority flag in bit 160, and the block routes it to a high or a low service class according to that flag. On each cycle it picks at most one entry and forwards its 160-bit payload to a single downstream sink. The priority flag is removed before the payload leaves. A weight parameter (0, 4 or 8) sets how often the low class is served when both classes have work waiting. Within a class, channels take turns in round-robin order.

Every channel input is a valid/ready stream with zero ready latency. An entry moves on a rising edge when `in_valid[c]` and `in_ready[c]` are both high. The output is a valid/ready stream with a ready latency of three cycles. The block may raise `out_valid` only in a cycle whose `out_ready` was high three cycles earlier, and every cycle with `out_valid` high is a transfer. A small output buffer holds accepted entries until the sink can take them. The scheduler stops granting while the buffer is full, so nothing is lost or repeated.

A flush input removes queued entries that carry a given 8-bit ID in payload bits [7:0]. A flushed entry is discarded and is never presented to the sink.

Top module: `wq_desc_sched`

## Requirements
- R1: While `rst_n` is low, `in_ready` is all zeros and `out_valid` is low.
- R2: At most one bit of `in_ready` is high in any cycle. It is high only for a channel whose `in_valid` is high, and only while the output buffer holds fewer than `BUF_DEPTH` entries, counted before any removal in that cycle.
- R3: The payload presented on `out_desc` equals bits [159:0] of the accepted entry, with bit 160 removed. Entries leave in the order they were accepted.
- R4: With weight W > 0 and both classes pending, the high class (bit 160 = 1) receives grants until W high grants have been made since the last low grant. The next grant then goes to the low class. A high grant adds one to the run count, saturating at W, and a low grant clears it to zero.
- R5: When only one class has a pending entry, that class is granted in every cycle in which the buffer has room, whatever the run count is.
- R6: Within a class, the grant goes to the first requesting channel after the last channel granted in that class, wrapping around. After reset, channel 0 is searched first.
- R7: `out_valid` is high only when `out_ready` was high three cycles earlier. Each cycle with `out_valid` high transfers exactly one entry.
- R8: Every accepted entry that is not flushed is delivered exactly once, even while `out_ready` stays low for long periods.
- R9: When `flush_en` is high in a cycle, every buffered entry whose bits [7:0] equal `flush_id` is marked at that edge, and so is an entry accepted in that same cycle. A marked entry is dropped when it reaches the head and is never shown on the output. An entry already transferring in the flush cycle is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | NUM_CH | Per-channel entry valid |
| in_ready | output | NUM_CH | Per-channel grant, zero-latency ready |
| in_desc | input | NUM_CH*161 | Channel entries packed side by side; channel c uses bits [c*161 +: 161], and bit 160 of each is the priority flag |
| out_valid | output | 1 | Payload valid; every assertion is a transfer |
| out_ready | input | 1 | Sink ready, with a latency of three cycles |
| out_desc | output | 160 | Payload without the priority flag |
| flush_en | input | 1 | Flush strobe |
| flush_id | input | 8 | ID compared with payload bits [7:0] |

## Verification
`in_ready` is combinational in the current inputs and state, so it is due in the same cycle as `in_valid`. An entry accepted at edge k can appear on `out_desc` no earlier than the cycle after k, and only in a cycle whose `out_ready` was high three edges before. A flush changes the output from the following cycle. The bench drives inputs just after each rising edge, and at the falling edge it compares the outputs with a behavioural model that uses plain queues and integers. It then advances the model by one edge, so every comparison falls in the cycle in which the result is due.

// File: rtl/wq_pkg.sv
package wq_pkg;
  localparam int PAY_W   = 160;
  localparam int ENTRY_W = PAY_W + 1;
  localparam int PRIO_B  = PAY_W;
  localparam int ID_W    = 8;
  localparam int RDY_LAT = 3;
endpackage

// File: rtl/wq_rr_pick.sv
module wq_rr_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);
  always_comb begin
    any     = 1'b0;
    gnt_idx = last;
    for (int k = 1; k <= N; k++) begin
      automatic int cand = (int'(last) + k) % N;
      if (!any && req[cand]) begin
        any     = 1'b1;
        gnt_idx = IW'(cand);
      end
    end
    gnt = '0;
    if (any) gnt[gnt_idx] = 1'b1;
  end
endmodule

// File: rtl/wq_weight_sel.sv
module wq_weight_sel #(
  parameter int WEIGHT = 4,
  localparam int RW = (WEIGHT < 1) ? 1 : $clog2(WEIGHT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_any,
  input  logic lo_any,
  input  logic take,
  output logic pick_hi
);
  generate
    if (WEIGHT == 0) begin : g_strict
      assign pick_hi = hi_any;
    end else begin : g_weighted
      logic [RW-1:0] hi_run;
      logic [7:0]    streak;

      assign pick_hi = hi_any && (!lo_any || (hi_run < RW'(WEIGHT)));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          hi_run <= '0;
        end else if (take) begin
          if (!pick_hi)                    hi_run <= '0;
          else if (hi_run != RW'(WEIGHT))  hi_run <= hi_run + 1'b1;
        end
      end

      // independent count of high grants made while low work waited
      always_ff @(posedge clk) begin
        if (!rst_n)                               streak <= '0;
        else if (take && !pick_hi)                streak <= '0;
        else if (take && lo_any && streak != 8'hFF) streak <= streak + 1'b1;
      end

      p_lo_not_starved_r4: assert property (@(posedge clk) disable iff (!rst_n)
        streak <= 8'(WEIGHT));
    end
  endgenerate
endmodule

// File: rtl/wq_out_buf.sv
module wq_out_buf #(
  parameter int DEPTH = 4,
  parameter int W     = 160,
  parameter int IDW   = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         space,
  input  logic         flush_en,
  input  logic [IDW-1:0] flush_id,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic [W-1:0]  mem  [DEPTH];
  logic [DEPTH-1:0] kill;
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic [wq_pkg::RDY_LAT-1:0] rdy_sr;
  logic          nonempty, pop;

  assign nonempty  = (count != '0);
  assign space     = (count < CW'(DEPTH));
  assign out_valid = nonempty && !kill[rd_ptr] && rdy_sr[wq_pkg::RDY_LAT-1];
  assign pop       = nonempty && (kill[rd_ptr] || rdy_sr[wq_pkg::RDY_LAT-1]);
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_sr <= '0;
    else        rdy_sr <= {rdy_sr[wq_pkg::RDY_LAT-2:0], out_ready};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push && space) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      count <= count + CW'(push && space) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kill <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (flush_en && mem[i][IDW-1:0] == flush_id) kill[i] <= 1'b1;
      if (push && space)
        kill[wr_ptr] <= flush_en && (push_data[IDW-1:0] == flush_id);
    end
  end

  always_ff @(posedge clk) begin
    if (push && space) mem[wr_ptr] <= push_data;
  end

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CW'(DEPTH)));
  p_ready_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && out_valid) |-> $past(out_ready, 3));
  p_valid_needs_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !out_valid);
endmodule

// File: rtl/wq_desc_sched.sv
module wq_desc_sched #(
  parameter int NUM_CH    = 4,
  parameter int WEIGHT    = 4,
  parameter int BUF_DEPTH = 4,
  localparam int EW = wq_pkg::ENTRY_W,
  localparam int PW = wq_pkg::PAY_W,
  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CH-1:0]    in_valid,
  output logic [NUM_CH-1:0]    in_ready,
  input  logic [NUM_CH*EW-1:0] in_desc,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PW-1:0]        out_desc,
  input  logic                 flush_en,
  input  logic [wq_pkg::ID_W-1:0] flush_id
);
  logic [NUM_CH-1:0] prio, hi_req, lo_req, gnt_hi, gnt_lo;
  logic [IW-1:0]     last_hi, last_lo, idx_hi, idx_lo, win;
  logic              hi_any, lo_any, pick_hi, space, take;
  logic [PW-1:0]     win_pay;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign prio[c] = in_desc[c*EW + wq_pkg::PRIO_B];
    end
  endgenerate

  assign hi_req = in_valid & prio;
  assign lo_req = in_valid & ~prio;

  wq_rr_pick #(.N(NUM_CH)) u_rr_hi (
    .req(hi_req), .last(last_hi), .gnt(gnt_hi), .gnt_idx(idx_hi), .any(hi_any));
  wq_rr_pick #(.N(NUM_CH)) u_rr_lo (
    .req(lo_req), .last(last_lo), .gnt(gnt_lo), .gnt_idx(idx_lo), .any(lo_any));

  assign take = rst_n && space && (hi_any || lo_any);

  wq_weight_sel #(.WEIGHT(WEIGHT)) u_wsel (
    .clk(clk), .rst_n(rst_n), .hi_any(hi_any), .lo_any(lo_any),
    .take(take), .pick_hi(pick_hi));

  assign in_ready = !take ? '0 : (pick_hi ? gnt_hi : gnt_lo);
  assign win      = pick_hi ? idx_hi : idx_lo;
  assign win_pay  = in_desc[int'(win)*EW +: PW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_hi <= IW'(NUM_CH - 1);
      last_lo <= IW'(NUM_CH - 1);
    end else if (take) begin
      if (pick_hi) last_hi <= idx_hi;
      else         last_lo <= idx_lo;
    end
  end

  wq_out_buf #(.DEPTH(BUF_DEPTH), .W(PW), .IDW(wq_pkg::ID_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(take), .push_data(win_pay), .space(space),
    .flush_en(flush_en), .flush_id(flush_id), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_desc));

  p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));
  p_grant_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0);
  always_comb begin
    if (!rst_n) p_reset_quiet_r1: assert (in_ready == '0);
  end
endmodule

// File: tb/wq_desc_sched_test.sv
`timescale 1ns/1ps
module wq_desc_sched_test;
  localparam int N = 4, WT = 4, DEPTH = 4, EW = 161;

  logic clk = 0, rst_n = 0, out_ready = 0, flush_en = 0, out_valid;
  logic [7:0] flush_id = '0;
  logic [N-1:0] in_valid = '0, in_ready;
  logic [N*EW-1:0] in_desc = '0;
  logic [159:0] out_desc;

  always #2 clk = ~clk;

  wq_desc_sched #(.NUM_CH(N), .WEIGHT(WT), .BUF_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_desc(in_desc), .out_valid(out_valid), .out_ready(out_ready),
    .out_desc(out_desc), .flush_en(flush_en), .flush_id(flush_id));

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  logic [160:0] src [N][$];
  logic [159:0] mq[$];
  bit mk[$];
  bit rh[3];
  bit killed_id[256];
  int hi_run, last_hi, last_lo, next_id = 0;
  int issued = 0, delivered = 0, n_killed = 0;

  task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int rr(input bit [N-1:0] req, input int last);
    for (int k = 1; k <= N; k++) if (req[(last + k) % N]) return (last + k) % N;
    return -1;
  endfunction

  task automatic add(input int ch, input bit p, input int n);
    for (int i = 0; i < n; i++) begin
      src[ch].push_back({p, 8'(ch), 144'(next_id * 7 + 3), 8'(next_id)});
      next_id++; issued++;
    end
  endtask

  task automatic tick();
    bit [N-1:0] hr, lr;
    bit hi_any, lo_any, ph, exp_ov;
    int w;
    logic [N-1:0] exp_rdy;
    for (int c = 0; c < N; c++) begin
      in_valid[c] = src[c].size() > 0;
      in_desc[c*EW +: EW] = (src[c].size() > 0) ? src[c][0] : '0;
    end
    @(negedge clk);
    exp_rdy = '0; exp_ov = 0; w = -1; ph = 0;
    if (rst_n) begin
      for (int c = 0; c < N; c++) begin
        hr[c] = in_valid[c] && in_desc[c*EW + 160];
        lr[c] = in_valid[c] && !in_desc[c*EW + 160];
      end
      hi_any = hr != 0; lo_any = lr != 0;
      if (mq.size() < DEPTH && (hi_any || lo_any)) begin
        ph = hi_any && (!lo_any || WT == 0 || hi_run < WT);
        w = ph ? rr(hr, last_hi) : rr(lr, last_lo);
        exp_rdy[w] = 1'b1;
      end
      exp_ov = mq.size() > 0 && !mk[0] && rh[2];
    end
    chk(tag, 160'(in_ready), 160'(exp_rdy));
    chk("R7", 160'(out_valid), 160'(exp_ov));
    if (exp_ov && out_valid) chk("R3", out_desc, mq[0]);
    if (out_valid === 1'b1) chk("R9", 160'(killed_id[out_desc[7:0]]), 160'(0));
    if (!rst_n) begin
      mq.delete(); mk.delete(); rh = '{0, 0, 0};
      hi_run = 0; last_hi = N - 1; last_lo = N - 1;
    end else begin
      if (mq.size() > 0 && (mk[0] || rh[2])) begin
        if (!mk[0]) delivered++;
        void'(mq.pop_front()); void'(mk.pop_front());
      end
      if (flush_en)
        foreach (mq[i]) if (mq[i][7:0] == flush_id && !mk[i]) begin
          mk[i] = 1; killed_id[flush_id] = 1; n_killed++;
        end
      if (w >= 0) begin
        bit kf = flush_en && src[w][0][7:0] == flush_id;
        mq.push_back(src[w][0][159:0]); mk.push_back(kf);
        if (kf) begin killed_id[flush_id] = 1; n_killed++; end
        void'(src[w].pop_front());
        if (ph) begin hi_run = (hi_run == WT) ? WT : hi_run + 1; last_hi = w; end
        else begin hi_run = 0; last_lo = w; end
      end
      rh[2] = rh[1]; rh[1] = rh[0]; rh[0] = out_ready;
    end
    @(posedge clk); #1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  function automatic bit idle();
    for (int c = 0; c < N; c++) if (src[c].size() > 0) return 0;
    return mq.size() == 0;
  endfunction

  initial begin
    #(100000 * 4);
    n_bad++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int fid;
    @(posedge clk); #1;
    tag = "R1"; add(0, 1, 2); run(3);         // reset holds grants and output low
    rst_n = 1; out_ready = 1;
    tag = "R5"; run(4); add(2, 1, 4); add(0, 1, 4); run(14);
    add(1, 0, 5); add(3, 0, 3); run(14);      // only low class pending
    tag = "R6"; for (int c = 0; c < N; c++) add(c, 1, 3); run(16);
    tag = "R4"; add(0, 1, 10); add(1, 0, 6); add(2, 1, 8); add(3, 0, 6); run(50);
    tag = "R8";
    for (int c = 0; c < N; c++) add(c, c[0], 5);
    for (int i = 0; i < 60; i++) begin out_ready = (i % 7) < 3; tick(); end
    out_ready = 0; run(12); out_ready = 1; run(24);
    tag = "R9"; out_ready = 0; run(4);
    fid = next_id + 1; add(0, 1, 3); add(1, 0, 1); run(6);
    flush_en = 1; flush_id = 8'(fid); tick(); flush_en = 0;
    out_ready = 1; run(15);
    tag = "R2";
    for (int i = 0; i < 400 && !idle(); i++) tick();
    run(4);
    chk("R9", 160'(n_killed), 160'(1));
    chk("R8", 160'(delivered), 160'(issued - n_killed));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule